// File: doc/BRIEF.md
# Memory Self-Test Control Register

This block is one host-visible control and status register that runs a March C- self-test on four independent on-chip RAMs. The four RAMs are two data stores (backplane and local) and two connection stores (backplane and local). Each RAM has its own group of three bits: a start bit that the host writes, and done and pass bits that the host can only read. One global enable bit decides whether any test may start.

To run a test, the host sets the enable bit and then raises one or more start bits. It then polls the done bits. When a done bit is high, the matching pass bit gives the verdict. Each RAM has its own test engine, and the engines can run at the same time. While an engine is running, it alone drives the address, write-enable and write-data pins of its RAM. The RAM models have an optional stuck-at-1 bit, chosen by parameter, so that a failing verdict can be produced.

Top module: `mbist_ctrl_top`

## Requirements
- R1: After reset, every register field is 0. A read returns the 13-bit register in bits 12..0, and bits 15..13 read as 0. Read data is registered, so it shows the register state one clock after that state changes.
- R2: Bit 12 is the test enable. A start edge that arrives while bit 12 is 0 starts no test. If bit 12 is later set while a start bit is already high, that start bit still gets no new edge, so no test runs.
- R3: A test starts only when its start bit goes from 0 to 1. Holding the start bit high, or writing 1 again over a 1, does not restart the test.
- R4: Each RAM has a group of bits: start, done, pass, from the upper bit down. The groups sit at bits 11..9 (backplane data), 8..6 (local data), 5..3 (backplane connection) and 2..0 (local connection). The done bit goes to 1 when its memory's March C- run completes, and it stays at 1 until the next accepted start.
- R5: The pass bit is 1 after a run with no read mismatch and 0 after a run with a mismatch. It is never 1 while its done bit is 0.
- R6: When a start is accepted, that memory's done and pass bits clear to 0 on the next clock and stay at 0 until the new run ends.
- R7: A start edge that arrives while that memory's engine is running is ignored. The run in progress is neither restarted nor lengthened.
- R8: The four engines run independently and can run at the same time. Each engine reports its own done and pass bits.
- R9: Host writes to the done and pass positions have no effect on those bits.
- R10: The March sequence runs six elements: write 0 ascending; read 0 then write 1 ascending; read 1 then write 0 ascending; read 0 then write 1 descending; read 1 then write 0 descending; read 0 ascending. A stuck-at-1 cell is caught as a fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 16 | Write data; only bit 12 and the four start bits are stored |
| host_rdata | output | 16 | Registered read-back of the register |

## Verification
The assertions check, on every clock, these rules:
- A pass bit is never high while its done bit is low.
- A done bit stays high until the next accepted start.
- An accepted start clears done and pass on the next clock.
- An engine begins only after a clean start edge taken while the enable bit was high.
- Every run ends with a completion pulse.

Some behaviour can only be shown by the bench's scenarios, because it concerns outcomes over time:
- A start edge that arrives mid-run does not lengthen the run; the bench compares run durations to show this.
- A stuck-at cell yields a fail verdict while healthy memories pass.
- Concurrent runs finish independently.
- Random writes to the done and pass positions leave those bits unchanged.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int NUM_MEM = 4;
  localparam int REG_W   = 16;
  localparam int EN_POS  = 12;
  localparam int USED_W  = 13;

  // group g: 0 local conn, 1 backplane conn, 2 local data, 3 backplane data
  function automatic int start_pos(input int g);
    return 3 * g + 2;
  endfunction
  function automatic int done_pos(input int g);
    return 3 * g + 1;
  endfunction
  function automatic int pass_pos(input int g);
    return 3 * g;
  endfunction

  typedef enum logic [2:0] {
    EL_W0_UP   = 3'd0,
    EL_R0W1_UP = 3'd1,
    EL_R1W0_UP = 3'd2,
    EL_R0W1_DN = 3'd3,
    EL_R1W0_DN = 3'd4,
    EL_R0_UP   = 3'd5
  } march_el_t;
endpackage

// File: rtl/mbist_ram.sv
module mbist_ram #(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter bit FAULTY    = 1'b0,
  parameter int FLT_ADDR  = 0,
  parameter int FLT_BIT   = 0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] FLT_MASK = DW'(1) << FLT_BIT;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rd_q <= mem[addr_i];
  end

  generate
    if (FAULTY) begin : g_stuck
      logic hit_q;
      always_ff @(posedge clk) hit_q <= (addr_i == AW'(FLT_ADDR));
      assign rdata_o = hit_q ? (rd_q | FLT_MASK) : rd_q;
    end else begin : g_clean
      assign rdata_o = rd_q;
    end
  endgenerate
endmodule

// File: rtl/mbist_march.sv
module mbist_march
  import mbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i
);
  localparam logic [AW-1:0] ADDR_MAX = '1;

  march_el_t     el_q;
  logic          phase_q;
  logic [AW-1:0] addr_q;
  logic          fail_q;

  logic exp_bit, wr_bit, desc, last_addr, mismatch, step, next_desc;

  always_comb begin
    unique case (el_q)
      EL_R0W1_UP: begin exp_bit = 1'b0; wr_bit = 1'b1; end
      EL_R1W0_UP: begin exp_bit = 1'b1; wr_bit = 1'b0; end
      EL_R0W1_DN: begin exp_bit = 1'b0; wr_bit = 1'b1; end
      EL_R1W0_DN: begin exp_bit = 1'b1; wr_bit = 1'b0; end
      default:    begin exp_bit = 1'b0; wr_bit = 1'b0; end
    endcase
  end

  assign desc      = (el_q == EL_R0W1_DN) || (el_q == EL_R1W0_DN);
  assign next_desc = (el_q == EL_R1W0_UP) || (el_q == EL_R0W1_DN);
  assign last_addr = desc ? (addr_q == '0) : (addr_q == ADDR_MAX);
  assign step      = (el_q == EL_W0_UP) || phase_q;
  assign mismatch  = busy_o && phase_q && (el_q != EL_W0_UP) &&
                     (ram_rdata_i != {DW{exp_bit}});

  assign ram_addr_o  = busy_o ? addr_q : '0;
  assign ram_we_o    = busy_o && ((el_q == EL_W0_UP) || (phase_q && el_q != EL_R0_UP));
  assign ram_wdata_o = busy_o ? {DW{wr_bit}} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
      el_q    <= EL_W0_UP;
      phase_q <= 1'b0;
      addr_q  <= '0;
      fail_q  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o  <= 1'b1;
          el_q    <= EL_W0_UP;
          phase_q <= 1'b0;
          addr_q  <= '0;
          fail_q  <= 1'b0;
        end
      end else begin
        if (mismatch) fail_q <= 1'b1;
        if (el_q != EL_W0_UP) phase_q <= ~phase_q;
        if (step) begin
          if (last_addr) begin
            if (el_q == EL_R0_UP) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
              pass_o <= !(fail_q || mismatch);
            end else begin
              el_q   <= march_el_t'(el_q + 3'd1);
              addr_q <= next_desc ? ADDR_MAX : '0;
            end
          end else begin
            addr_q <= desc ? addr_q - 1'b1 : addr_q + 1'b1;
          end
        end
      end
    end
  end

  // R4: every run ends with a completion pulse
  p_end_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R10: a write-only first element never compares read data
  p_first_elem_writes_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && el_q == EL_W0_UP) |-> ram_we_o && (ram_wdata_o == '0));
endmodule

// File: rtl/mbist_csr.sv
module mbist_csr
  import mbist_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [REG_W-1:0]   host_wdata,
  output logic [REG_W-1:0]   host_rdata,
  input  logic [NUM_MEM-1:0] busy_i,
  input  logic [NUM_MEM-1:0] done_i,
  input  logic [NUM_MEM-1:0] pass_i,
  output logic [NUM_MEM-1:0] accept_o
);
  logic               en_q;
  logic [NUM_MEM-1:0] start_q, start_prev_q, done_q, pass_q;
  logic [USED_W-1:0]  image;
  logic [REG_W-1:0]   unused_wdata;

  assign unused_wdata = host_wdata;
  assign accept_o = start_q & ~start_prev_q & ~busy_i & {NUM_MEM{en_q}};

  always_comb begin
    image = '0;
    image[EN_POS] = en_q;
    for (int g = 0; g < NUM_MEM; g++) begin
      image[start_pos(g)] = start_q[g];
      image[done_pos(g)]  = done_q[g];
      image[pass_pos(g)]  = pass_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= 1'b0;
      start_q      <= '0;
      start_prev_q <= '0;
      host_rdata   <= '0;
    end else begin
      start_prev_q <= start_q;
      host_rdata   <= REG_W'(image);
      if (host_wr) begin
        en_q <= host_wdata[EN_POS];
        for (int g = 0; g < NUM_MEM; g++) start_q[g] <= host_wdata[start_pos(g)];
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_flags
      always_ff @(posedge clk) begin
        if (rst) begin
          done_q[g] <= 1'b0;
          pass_q[g] <= 1'b0;
        end else if (accept_o[g]) begin
          done_q[g] <= 1'b0;
          pass_q[g] <= 1'b0;
        end else if (done_i[g]) begin
          done_q[g] <= 1'b1;
          pass_q[g] <= pass_i[g];
        end
      end

      p_clear_on_start_r6: assert property (@(posedge clk) disable iff (rst)
        accept_o[g] |=> !done_q[g] && !pass_q[g]);
      p_pass_needs_done_r5: assert property (@(posedge clk) disable iff (rst)
        pass_q[g] |-> done_q[g]);
      p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (done_q[g] && !accept_o[g]) |=> done_q[g]);
      p_run_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_i[g]) |-> $past(en_q));
      p_run_needs_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_i[g]) |-> $past(start_q[g] && !start_prev_q[g]));
    end
  endgenerate
endmodule

// File: rtl/mbist_ctrl_top.sv
module mbist_ctrl_top
  import mbist_pkg::*;
#(
  parameter int              AW_DATA    = 5,
  parameter int              DW_DATA    = 8,
  parameter int              AW_CONN    = 4,
  parameter int              DW_CONN    = 16,
  parameter logic [3:0]      FAULT_MASK = 4'b0000,
  parameter int              FAULT_ADDR = 3,
  parameter int              FAULT_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata
);
  logic [NUM_MEM-1:0] busy, done, pass, accept;

  mbist_csr u_csr (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy_i     (busy),
    .done_i     (done),
    .pass_i     (pass),
    .accept_o   (accept)
  );

  generate
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
      localparam int AW = (g >= 2) ? AW_DATA : AW_CONN;
      localparam int DW = (g >= 2) ? DW_DATA : DW_CONN;

      logic [AW-1:0] addr;
      logic          we;
      logic [DW-1:0] wdata, rdata;

      mbist_march #(.AW(AW), .DW(DW)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .start_i     (accept[g]),
        .busy_o      (busy[g]),
        .done_o      (done[g]),
        .pass_o      (pass[g]),
        .ram_addr_o  (addr),
        .ram_we_o    (we),
        .ram_wdata_o (wdata),
        .ram_rdata_i (rdata)
      );

      mbist_ram #(
        .AW(AW), .DW(DW), .FAULTY(FAULT_MASK[g]),
        .FLT_ADDR(FAULT_ADDR), .FLT_BIT(FAULT_BIT)
      ) u_ram (
        .clk     (clk),
        .addr_i  (addr),
        .we_i    (we),
        .wdata_i (wdata),
        .rdata_o (rdata)
      );

      // R8: an idle engine leaves its RAM untouched
      p_idle_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy[g] && !$past(busy[g])) |-> !we);
    end
  endgenerate
endmodule

// File: tb/test_mbist_ctrl_top.sv
module test_mbist_ctrl_top;
  localparam logic [15:0] EN = 16'h1000;
  localparam logic [15:0] ST_ALL = 16'h0924;
  localparam logic [15:0] DN_ALL = 16'h0492;
  localparam logic [15:0] PS_ALL = 16'h0249;

  logic clk = 0, rst = 1;
  logic h_wr = 0, f_wr = 0;
  logic [15:0] h_wd = 0, f_wd = 0, h_rd, f_rd;
  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  mbist_ctrl_top i_mbist_ctrl_top (.clk(clk), .rst(rst), .host_wr(h_wr),
    .host_wdata(h_wd), .host_rdata(h_rd));
  mbist_ctrl_top #(.FAULT_MASK(4'b1010)) i_mbist_ctrl_top_flt (.clk(clk), .rst(rst),
    .host_wr(f_wr), .host_wdata(f_wd), .host_rdata(f_rd));

  function automatic logic [15:0] st(input int g); return 16'(1) << (3*g+2); endfunction
  function automatic logic [15:0] dn(input int g); return 16'(1) << (3*g+1); endfunction
  function automatic logic [15:0] ps(input int g); return 16'(1) << (3*g); endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit flt, input logic [15:0] v);
    @(negedge clk);
    if (flt) begin f_wr = 1; f_wd = v; end else begin h_wr = 1; h_wd = v; end
    @(negedge clk);
    f_wr = 0; h_wr = 0;
  endtask

  task automatic rd(input bit flt, output logic [15:0] v);
    @(negedge clk); @(negedge clk);
    v = flt ? f_rd : h_rd;
  endtask

  task automatic wait_bits(input bit flt, input logic [15:0] m, output int t);
    int n = 0;
    while (((flt ? f_rd : h_rd) & m) != m && n < 6000) begin @(negedge clk); n++; end
    if (n >= 6000) begin tests++; fails++; $display("FAIL R4 timeout actual=%h expected=%h",
      (flt ? f_rd : h_rd) & m, m); end
    t = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, r;
    int t0, t1, base;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst = 0;
    rd(0, r); chk("R1 reset clean", r, 16'h0000);
    rd(1, r); chk("R1 reset faulty", r, 16'h0000);

    // R9 / R2: random writes with enable low
    for (int i = 0; i < 30; i++) begin
      v = 16'($urandom);
      v[12] = 1'b0;
      wr(0, v);
      rd(0, r);
      chk("R9 R2 random write", r, v & ST_ALL);
    end
    // R2: starts high, then enable set without new edge
    wr(0, ST_ALL);
    wr(0, EN | ST_ALL);
    repeat (600) @(negedge clk);
    rd(0, r); chk("R2 no run without edge", r, EN | ST_ALL);
    wr(0, EN);

    // R4 R5: single run on local connection memory
    wr(0, EN | st(0)); t0 = cyc;
    wait_bits(0, dn(0), t1); base = t1 - t0;
    rd(0, r); chk("R4 R5 single pass", r, EN | st(0) | dn(0) | ps(0));

    // R3: hold high and rewrite 1
    repeat (300) @(negedge clk);
    wr(0, EN | st(0));
    repeat (300) @(negedge clk);
    rd(0, r); chk("R3 no restart on hold", r, EN | st(0) | dn(0) | ps(0));

    // R9: writes to done/pass positions ignored
    wr(0, EN | st(0) | (DN_ALL | PS_ALL));
    rd(0, r); chk("R9 ro bits set attempt", r, EN | st(0) | dn(0) | ps(0));
    wr(0, EN | st(0));
    rd(0, r); chk("R9 ro bits clear attempt", r, EN | st(0) | dn(0) | ps(0));

    // R6: new start clears done and pass
    wr(0, EN);
    wr(0, EN | st(0));
    rd(0, r); chk("R6 clear on start", r, EN | st(0));
    wait_bits(0, dn(0), t1);
    rd(0, r); chk("R6 done after rerun", r, EN | st(0) | dn(0) | ps(0));

    // R7: edge mid-run ignored, duration unchanged
    wr(0, EN);
    wr(0, EN | st(0)); t0 = cyc;
    repeat (20) @(negedge clk);
    wr(0, EN);
    wr(0, EN | st(0));
    wait_bits(0, dn(0), t1);
    chk("R7 run length unchanged", 16'(t1 - t0), 16'(base));

    // R8 R5 R10: all four concurrent, on both instances
    wr(0, EN); wr(1, EN);
    fork
      wr(0, EN | ST_ALL);
      wr(1, EN | ST_ALL);
    join
    rd(0, r); chk("R8 all cleared", r & (DN_ALL | PS_ALL), 16'h0000);
    wait_bits(0, DN_ALL, t1);
    wait_bits(1, DN_ALL, t1);
    rd(0, r); chk("R8 concurrent pass", r, EN | ST_ALL | DN_ALL | PS_ALL);
    rd(1, r); chk("R5 R10 stuck cells fail", r, EN | ST_ALL | DN_ALL | ps(0) | ps(2));
    rd(1, r); chk("R5 healthy groups pass", r & (ps(0) | ps(2)), ps(0) | ps(2));

    // R2: enable off blocks a fresh edge on faulty instance
    wr(1, 16'h0000);
    wr(1, ST_ALL);
    repeat (50) @(negedge clk);
    rd(1, r); chk("R2 edge ignored enable low", r, ST_ALL | DN_ALL | ps(0) | ps(2));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule